// File: doc/BRIEF.md
# Ramp Oscillator Chorus Address Generator

This block holds two free-running ramp oscillators for a delay-line effects engine. Each ramp has a fixed-point phase: 12 integer bits of memory location and 8 fraction bits. On every sample tick the phase moves up by a programmed rate and wraps inside a power-of-two span. A controller can reload a ramp's rate and span or force its phase back to zero. It then issues chorus reads that combine the ramp with a base address.

For each chorus read the block returns two values one cycle later. The first is a delay-memory address: the base address plus the integer part of the (possibly modified) ramp phase, wrapped to a 15-bit address space. The second is a 9-bit coefficient. In normal mode it is the fractional part of the phase, or its complement, which gives linear interpolation between neighbouring samples. In crossfade mode it is a triangle weight that rises to full scale at mid-ramp and falls to zero at the wrap points. A pitch shifter uses two reads that sit half a span apart and crossfades between them.

Top module: `ramp_cho_agen`

## Requirements
- R1: After reset every ramp has phase 0, rate 0, amplitude code 0 and a held copy of 0, and `valid_o` is low. A latching request on either ramp then returns the base address with coefficient 0.
- R2: A load (`ld_i`) on the ramp chosen by `ctl_sel_i` stores a 16-bit rate and a 2-bit amplitude code, and clears that ramp's phase. The amplitude code selects the span: codes 0, 1, 2 and 3 give 4096, 2048, 1024 and 512 locations. A load wins over a tick in the same cycle.
- R3: On each cycle with `tick_i` high, a ramp's phase grows by its rate, counted in 1/256 of a location, and wraps modulo its span. Without a tick, load or jam the phase does not change.
- R4: A jam (`jam_i`) clears the selected ramp's phase, wins over a tick in the same cycle, and keeps the rate.
- R5: A request (`req_i`) produces its result on `addr_o`/`coef_o` with `valid_o` high in the next cycle. `valid_o` is low in every cycle that follows a cycle without a request.
- R6: Flag bit 1 captures the ramp's phase as it stood before any tick in that cycle, and the request uses that captured value. A request without bit 1 uses the phase captured last, whatever ticks have passed since.
- R7: In normal mode the address is the base plus the integer part (phase bits 19..8), modulo 32768.
- R8: In normal mode the coefficient is the fraction (phase bits 7..0) when flag bit 2 is clear, and 256 minus the fraction when it is set.
- R9: Flag bit 3 replaces the phase with its one's complement within the span (XOR with span×256−1) before the address and fraction are taken.
- R10: Flag bit 4 adds half the span to the phase, modulo the span. The address from such a read is exactly half a span from the address without it, and the fraction is the same.
- R11: Flag bit 5 returns the base address unchanged and a crossfade coefficient. With half = span×128, the value is floor(t·512/(span·256)), where t is the phase below half and span·256 minus the phase at or above half. Flag bit 2 has no effect in this mode.
- R12: The half-span offset is applied first. The crossfade is taken from the offset phase, and the complement is then applied to that offset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick; advances all ramps |
| ld_i | input | 1 | Load rate and amplitude code into the selected ramp |
| jam_i | input | 1 | Clear the selected ramp's phase |
| ctl_sel_i | input | 1 | Ramp selected for load and jam |
| ld_rate_i | input | 16 | Rate for a load |
| ld_amp_i | input | 2 | Amplitude code for a load |
| req_i | input | 1 | Chorus read request |
| req_sel_i | input | 1 | Ramp used by the request |
| req_flags_i | input | 5 | Flag bits 5..1 of the request |
| req_base_i | input | 15 | Base delay-memory address |
| valid_o | output | 1 | Result valid |
| addr_o | output | 15 | Delay-memory address |
| coef_o | output | 9 | Interpolation or crossfade coefficient, 256 = 1.0 |

## Verification
Two pairs of events can fall in the same cycle. The first is a sample tick together with a latching request on the same ramp. The bench drives both in one cycle and then issues a non-latching read. Both reads must show the phase from before that tick, not the advanced one. The second pair is a jam or a load together with a tick. The bench provokes it directly and judges it by a following latching read, which must return a zero phase. A later read after one more tick shows that the rate survived the jam.

// File: rtl/ramp_cho_pkg.sv
package ramp_cho_pkg;
  localparam int AMP_W   = 2;
  localparam int FLAG_LO = 1;
  localparam int FLAG_HI = 5;
  localparam int F_LATCH = 1;
  localparam int F_COMPC = 2;
  localparam int F_COMPA = 3;
  localparam int F_HALF  = 4;
  localparam int F_XFADE = 5;
  typedef logic [FLAG_HI:FLAG_LO] cho_flags_t;
endpackage

// File: rtl/ramp_osc.sv
module ramp_osc
  import ramp_cho_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int SPAN_W = 12,
  parameter int FRAC_W = 8,
  localparam int PH_W  = SPAN_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic              jam_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic              cap_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [PH_W-1:0]   hold_o,
  output logic [AMP_W-1:0]  amp_o
);
  logic [RATE_W-1:0] rate_q;
  logic [AMP_W-1:0]  amp_q;
  logic [PH_W-1:0]   phase_q, hold_q;
  logic [PH_W:0]     span_fx, sum, wrp;
  logic              unused_top;

  assign span_fx = (PH_W+1)'(1) << (PH_W - int'(amp_q));
  assign sum     = {1'b0, phase_q} + {{(PH_W+1-RATE_W){1'b0}}, rate_q};
  // rate is below the smallest span, so one subtraction wraps
  assign wrp     = (sum >= span_fx) ? sum - span_fx : sum;
  assign unused_top = wrp[PH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= '0;
      amp_q   <= '0;
      phase_q <= '0;
      hold_q  <= '0;
    end else begin
      if (cap_i) hold_q <= phase_q;
      if (ld_i) begin
        rate_q  <= rate_i;
        amp_q   <= amp_i;
        phase_q <= '0;
      end else if (jam_i) begin
        phase_q <= '0;
      end else if (tick_i) begin
        phase_q <= wrp[PH_W-1:0];
      end
    end
  end

  assign phase_o = phase_q;
  assign hold_o  = hold_q;
  assign amp_o   = amp_q;
endmodule

// File: rtl/cho_addr_calc.sv
module cho_addr_calc
  import ramp_cho_pkg::*;
#(
  parameter int SPAN_W = 12,
  parameter int FRAC_W = 8,
  parameter int MEM_AW = 15,
  localparam int PH_W   = SPAN_W + FRAC_W,
  localparam int COEF_W = FRAC_W + 1
) (
  input  logic [PH_W-1:0]   phase_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  cho_flags_t        flags_i,
  input  logic [MEM_AW-1:0] base_i,
  output logic [MEM_AW-1:0] addr_o,
  output logic [COEF_W-1:0] coef_o
);
  logic [PH_W-1:0]   mask, half, p_half, p_cmp, norm;
  logic [PH_W:0]     tri_v;
  logic [SPAN_W-1:0] ipart;
  logic [FRAC_W-1:0] frac;
  logic [COEF_W-1:0] xcoef, one_c;
  logic              unused_tri;

  assign mask   = {PH_W{1'b1}} >> amp_i;
  assign half   = (mask >> 1) + PH_W'(1);
  assign p_half = flags_i[F_HALF] ? ((phase_i + half) & mask) : phase_i;

  // normalise to full scale, then fold into a triangle
  assign norm   = p_half << amp_i;
  assign tri_v  = norm[PH_W-1] ? (((PH_W+1)'(1) << PH_W) - {1'b0, norm})
                               : {1'b0, norm};
  assign xcoef  = tri_v[PH_W-1 -: COEF_W];
  assign unused_tri = ^{tri_v[PH_W], tri_v[PH_W-COEF_W-1:0]};

  assign p_cmp  = flags_i[F_COMPA] ? (p_half ^ mask) : p_half;
  assign ipart  = p_cmp[PH_W-1:FRAC_W];
  assign frac   = p_cmp[FRAC_W-1:0];
  assign one_c  = COEF_W'(1) << FRAC_W;

  always_comb begin
    if (flags_i[F_XFADE]) begin
      addr_o = base_i;
      coef_o = xcoef;
    end else begin
      addr_o = base_i + MEM_AW'(ipart);
      coef_o = flags_i[F_COMPC] ? (one_c - {1'b0, frac}) : {1'b0, frac};
    end
  end
endmodule

// File: rtl/ramp_cho_agen.sv
module ramp_cho_agen
  import ramp_cho_pkg::*;
#(
  parameter int NUM_RAMPS = 2,
  parameter int RATE_W    = 16,
  parameter int SPAN_W    = 12,
  parameter int FRAC_W    = 8,
  parameter int MEM_AW    = 15,
  localparam int PH_W     = SPAN_W + FRAC_W,
  localparam int COEF_W   = FRAC_W + 1,
  localparam int SEL_W    = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic              jam_i,
  input  logic [SEL_W-1:0]  ctl_sel_i,
  input  logic [RATE_W-1:0] ld_rate_i,
  input  logic [AMP_W-1:0]  ld_amp_i,
  input  logic              req_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [FLAG_HI:FLAG_LO] req_flags_i,
  input  logic [MEM_AW-1:0] req_base_i,
  output logic              valid_o,
  output logic [MEM_AW-1:0] addr_o,
  output logic [COEF_W-1:0] coef_o
);
  logic [NUM_RAMPS-1:0][PH_W-1:0]  live_ph, hold_ph;
  logic [NUM_RAMPS-1:0][AMP_W-1:0] amp_all;
  logic [PH_W-1:0]   src_ph;
  logic [MEM_AW-1:0] addr_d;
  logic [COEF_W-1:0] coef_d;

  for (genvar k = 0; k < NUM_RAMPS; k++) begin : g_ramp
    ramp_osc #(.RATE_W(RATE_W), .SPAN_W(SPAN_W), .FRAC_W(FRAC_W)) osc_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .ld_i    (ld_i  && (ctl_sel_i == SEL_W'(k))),
      .jam_i   (jam_i && (ctl_sel_i == SEL_W'(k))),
      .rate_i  (ld_rate_i),
      .amp_i   (ld_amp_i),
      .cap_i   (req_i && req_flags_i[F_LATCH] && (req_sel_i == SEL_W'(k))),
      .phase_o (live_ph[k]),
      .hold_o  (hold_ph[k]),
      .amp_o   (amp_all[k])
    );
  end

  assign src_ph = req_flags_i[F_LATCH] ? live_ph[req_sel_i] : hold_ph[req_sel_i];

  cho_addr_calc #(.SPAN_W(SPAN_W), .FRAC_W(FRAC_W), .MEM_AW(MEM_AW)) calc_i (
    .phase_i (src_ph),
    .amp_i   (amp_all[req_sel_i]),
    .flags_i (req_flags_i),
    .base_i  (req_base_i),
    .addr_o  (addr_d),
    .coef_o  (coef_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      coef_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        addr_o <= addr_d;
        coef_o <= coef_d;
      end
    end
  end
endmodule

// File: rtl/ramp_cho_agen_chk.sv
module ramp_cho_agen_chk
  import ramp_cho_pkg::*;
#(
  parameter int NUM_RAMPS = 2,
  parameter int SPAN_W    = 12,
  parameter int FRAC_W    = 8,
  parameter int MEM_AW    = 15,
  localparam int PH_W     = SPAN_W + FRAC_W,
  localparam int COEF_W   = FRAC_W + 1,
  localparam int SEL_W    = (NUM_RAMPS > 1) ? $clog2(NUM_RAMPS) : 1
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            tick_i,
  input logic                            ld_i,
  input logic                            jam_i,
  input logic [SEL_W-1:0]                ctl_sel_i,
  input logic [AMP_W-1:0]                ld_amp_i,
  input logic                            req_i,
  input logic [FLAG_HI:FLAG_LO]          req_flags_i,
  input logic [MEM_AW-1:0]               req_base_i,
  input logic                            valid_o,
  input logic [MEM_AW-1:0]               addr_o,
  input logic [COEF_W-1:0]               coef_o,
  input logic [NUM_RAMPS-1:0][PH_W-1:0]  live_ph,
  input logic [NUM_RAMPS-1:0][AMP_W-1:0] amp_all
);
  localparam logic [COEF_W-1:0] FULL_C = COEF_W'(1) << FRAC_W;

  assert_valid_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_valid_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  assert_coef_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> coef_o <= FULL_C);
  assert_xfade_base_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_flags_i[F_XFADE]) |=> (addr_o == $past(req_base_i)));

  for (genvar k = 0; k < NUM_RAMPS; k++) begin : g_chk
    assert_phase_in_span_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_ph[k] & ~({PH_W{1'b1}} >> amp_all[k])) == '0);
    assert_phase_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !ld_i && !jam_i) |=> $stable(live_ph[k]));
    assert_jam_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (jam_i && !ld_i && ctl_sel_i == SEL_W'(k)) |=> live_ph[k] == '0);
    assert_load_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_i && ctl_sel_i == SEL_W'(k)) |=> (live_ph[k] == '0 && amp_all[k] == $past(ld_amp_i)));
  end
endmodule

bind ramp_cho_agen ramp_cho_agen_chk #(
  .NUM_RAMPS(NUM_RAMPS), .SPAN_W(SPAN_W), .FRAC_W(FRAC_W), .MEM_AW(MEM_AW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ld_i(ld_i), .jam_i(jam_i),
  .ctl_sel_i(ctl_sel_i), .ld_amp_i(ld_amp_i), .req_i(req_i),
  .req_flags_i(req_flags_i), .req_base_i(req_base_i), .valid_o(valid_o),
  .addr_o(addr_o), .coef_o(coef_o), .live_ph(live_ph), .amp_all(amp_all)
);

// File: tb/ramp_cho_agen_tb_top.sv
module ramp_cho_agen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, ld = 1'b0, jam = 1'b0, req = 1'b0;
  logic        ctl_sel = 1'b0, req_sel = 1'b0;
  logic [15:0] ld_rate = '0;
  logic [1:0]  ld_amp = '0;
  logic [5:1]  flags = '0;
  logic [14:0] base = '0;
  logic        valid;
  logic [14:0] addr;
  logic [8:0]  coef;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_rate[2], m_amp[2], m_ph[2], m_hold[2];

  // {ticks before, ramp, flags[5:0], base}
  localparam logic [25:0] VEC [NVEC] = '{
    {4'd3, 1'b0, 6'h02, 15'h0000},
    {4'd0, 1'b0, 6'h00, 15'h0100},
    {4'd2, 1'b0, 6'h04, 15'h0100},
    {4'd1, 1'b0, 6'h12, 15'h0000},
    {4'd0, 1'b0, 6'h08, 15'h0010},
    {4'd0, 1'b0, 6'h18, 15'h0010},
    {4'd5, 1'b1, 6'h02, 15'h0000},
    {4'd6, 1'b1, 6'h02, 15'h7FF0},
    {4'd0, 1'b1, 6'h20, 15'h1234},
    {4'd0, 1'b1, 6'h30, 15'h1234},
    {4'd4, 1'b0, 6'h22, 15'h0042},
    {4'd0, 1'b0, 6'h0C, 15'h7FFF},
    {4'd2, 1'b1, 6'h26, 15'h0000}
  };

  ramp_cho_agen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .ld_i(ld), .jam_i(jam),
    .ctl_sel_i(ctl_sel), .ld_rate_i(ld_rate), .ld_amp_i(ld_amp),
    .req_i(req), .req_sel_i(req_sel), .req_flags_i(flags), .req_base_i(base),
    .valid_o(valid), .addr_o(addr), .coef_o(coef)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(int fl, int b);
    if (fl & 32) return "R11";
    if ((fl & 16) && (fl & 8)) return "R12";
    if (fl & 16) return "R10";
    if (b >= 'h7000) return "R7";
    if (fl & 8) return "R9";
    if (fl & 4) return "R8";
    if (fl & 2) return "R3";
    return "R6";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_calc(int src, int amp, int fl, int b, output int ea, output int ec);
    int s, p, tv, xc;
    s = (4096 >> amp) * 256;
    p = src;
    if (fl & 16) p = (p + s/2) % s;
    tv = (p >= s/2) ? s - p : p;
    xc = tv * 512 / s;
    if (fl & 8) p = p ^ (s - 1);
    if (fl & 32) begin
      ea = b; ec = xc;
    end else begin
      ea = (b + (p >> 8)) % 32768;
      ec = (fl & 4) ? 256 - (p & 255) : (p & 255);
    end
  endtask

  task automatic step(bit tk, bit l, bit j, int cs, int rate, int amp,
                      bit rq, int rs, int fl, int b, string tag);
    int ea, ec, src;
    ea = 0; ec = 0;
    @(negedge clk);
    tick = tk; ld = l; jam = j; ctl_sel = cs[0]; ld_rate = rate[15:0]; ld_amp = amp[1:0];
    req = rq; req_sel = rs[0]; flags = fl[5:1]; base = b[14:0];
    if (rq) begin
      src = (fl & 2) ? m_ph[rs] : m_hold[rs];
      expect_calc(src, m_amp[rs], fl, b, ea, ec);
      if (fl & 2) m_hold[rs] = m_ph[rs];
    end
    for (int k = 0; k < 2; k++) begin
      if (l && cs == k) begin
        m_rate[k] = rate; m_amp[k] = amp; m_ph[k] = 0;
      end else if (j && cs == k) m_ph[k] = 0;
      else if (tk) m_ph[k] = (m_ph[k] + m_rate[k]) % ((4096 >> m_amp[k]) * 256);
    end
    @(posedge clk);
    #1;
    check("R5", "valid_o", int'(valid), int'(rq));
    if (rq) begin
      check(tag, "addr_o", int'(addr), ea);
      check(tag, "coef_o", int'(coef), ec);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a1, c1, a2, c2;
    for (int k = 0; k < 2; k++) begin
      m_rate[k] = 0; m_amp[k] = 0; m_ph[k] = 0; m_hold[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "valid_o in reset", int'(valid), 0);
    rst_ni = 1'b1;
    // R1: reset state through latching reads
    step(1, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0000, "R1");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h06, 'h0005, "R1");
    // R2: loads
    step(0, 1, 0, 0, 'h0180, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 1, 'h3000, 3, 0, 0, 0, 0, "R2");

    for (int v = 0; v < NVEC; v++) begin
      tick_n(int'(VEC[v][25:22]));
      step(0, 0, 0, 0, 0, 0, 1, int'(VEC[v][21]), int'(VEC[v][20:15]),
           int'(VEC[v][14:0]), tag_of(int'(VEC[v][20:15]), int'(VEC[v][14:0])));
    end

    // R6: tick and latching read in one cycle, then held read after more ticks
    step(1, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0000, "R6");
    a1 = int'(addr); c1 = int'(coef);
    tick_n(2);
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h00, 'h0000, "R6");
    check("R6", "held addr", int'(addr), a1);
    check("R6", "held coef", int'(coef), c1);

    // R3: no tick, phase frozen
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0000, "R3");
    a1 = int'(addr); c1 = int'(coef);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0000, "R3");
    check("R3", "frozen addr", int'(addr), a1);
    check("R3", "frozen coef", int'(coef), c1);

    // R4: jam with tick, then rate kept
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0020, "R4");
    check("R4", "jam addr", int'(addr), 'h20);
    check("R4", "jam coef", int'(coef), 0);
    tick_n(1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 'h02, 'h0000, "R4");
    check("R4", "rate kept coef", int'(coef), 'h80);

    // R2: load with tick in the same cycle
    step(1, 1, 0, 1, 'h0040, 2, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h02, 'h0000, "R2");
    check("R2", "load clears", int'(addr) + int'(coef), 0);

    // R10: pointers half a span apart
    tick_n(7);
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h02, 'h0000, "R10");
    a1 = int'(addr); c1 = int'(coef);
    tick_n(3);
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h10, 'h0000, "R10");
    a2 = int'(addr); c2 = int'(coef);
    check("R10", "half span distance", (a2 - a1 + 1024) % 1024, 512);
    check("R10", "same fraction", c2, c1);

    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule